// File: doc/BRIEF.md
# Prefetchable Memory Window Decoder

This block sits in a two-sided memory bridge. It holds the configuration state for one prefetchable memory window, and for each memory transaction it decides whether the bridge should claim it. Software programs the window through a small dword-addressed configuration port with byte enables. The window is 1MB-granular and supports 64-bit addresses. The lower base and limit fields live in one shared dword. Two further dwords hold the upper 32 address bits of the base and of the limit.

Transactions enter on a valid/ready stream. Each carries a 64-bit address, a dual-address-cycle flag, the side it was seen on, and the match results of the neighbouring I/O-window and legacy-display decoders. One result per accepted transaction leaves on a second valid/ready stream, one cycle after acceptance and in order. The result is either a downstream claim, an upstream claim, or no claim.

Back-pressure rules: a transaction is accepted on a clock edge where `txn_valid` and `txn_ready` are both high. `txn_ready` is high whenever the result register is empty or being drained (`res_ready` high). A pending result, and its valid flag, stay unchanged until `res_ready` is seen high.

Top module: `pfw_window_decoder`

## Requirements
- R1: After reset, dword 9 reads 0001_0001h and dwords 10 and 11 read 0. The window then spans addresses 0 through 000F_FFFFh, so a primary address of 0 or 000F_FFFFh is claimed downstream and 0010_0000h is not.
- R2: Dword index 9 (byte offset 24h) holds the base field in bits [15:4] and the limit field in bits [31:20]. Bits [3:0] and [19:16] always read 1h and ignore writes. Dword 10 holds the upper base and dword 11 the upper limit. Each byte changes only when its byte enable is set. Other dwords read 0 and ignore writes.
- R3: The effective base is {upper base, base field, 20 zero bits}. The effective limit is {upper limit, limit field, 20 one bits}. An address matches when base <= address <= limit, unsigned and inclusive at both ends.
- R4: When `txn_dac` is 0, the address used is {32'h0, txn_addr[31:0]}. Bits [63:32] of the port are ignored, so such a transaction can match only while the upper base is 0.
- R5: When `txn_dac` is 1, the full 64-bit address is compared.
- R6: When the 64-bit effective base exceeds the 64-bit effective limit, including the case decided by the upper halves alone, no address matches.
- R7: A primary-side transaction (`txn_from_sec`=0) yields a downstream claim exactly when it matches, and never an upstream claim.
- R8: A secondary-side transaction never yields a downstream claim. It yields an upstream claim exactly when it does not match and neither `io_win_hit` nor `vga_hit` is set.
- R9: When `mem_en` is 0 at acceptance, the result carries neither claim.
- R10: A result becomes valid the cycle after acceptance, in acceptance order. It is held stable with `res_valid` high while `res_ready` is low, and `txn_ready` equals !res_valid || res_ready.
- R11: `res_down` and `res_up` are never both high in a valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| mem_en | input | 1 | Memory space enable from the command register |
| txn_valid | input | 1 | Transaction present |
| txn_ready | output | 1 | Transaction accepted this edge if valid |
| txn_addr | input | 64 | Transaction address |
| txn_dac | input | 1 | 1 = dual address cycle (64-bit) |
| txn_from_sec | input | 1 | 1 = seen on the secondary side |
| io_win_hit | input | 1 | Neighbouring I/O window matched this transaction |
| vga_hit | input | 1 | Legacy display decode matched this transaction |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes result |
| res_down | output | 1 | Claim for downstream forwarding |
| res_up | output | 1 | Claim for upstream forwarding |

## Verification
The embedded properties watch, on every cycle, the properties that hold for any input: the result is held under stall and follows each acceptance, the two claims are exclusive, the side rules apply, memory-disable suppresses claims, and a reversed 64-bit window or a single-cycle access against a non-zero upper base never claims downstream. The register layout, the 1MB boundary values, the byte-enable merging and the exact claim chosen for a given window can only be shown by the bench's scenarios. Those scenarios compare every result against a reference model of the programmed window, including under random consumer stalls.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  localparam int GRAN_BITS = 20;
  localparam int FIELD_W   = 32 - GRAN_BITS;
  localparam int HALF_W    = 32;
  localparam logic [3:0] CAP64_NIBBLE = 4'h1;

  typedef struct packed {
    logic down;
    logic up;
  } claim_t;

  // Merge a 12-bit window field with the writable part of a 16-bit lane pair
  function automatic logic [FIELD_W-1:0] merge_field(
    input logic [FIELD_W-1:0] cur,
    input logic [FIELD_W-1:0] wd,
    input logic [1:0]         be
  );
    logic [FIELD_W-1:0] res;
    res = cur;
    if (be[0]) res[3:0] = wd[3:0];
    if (be[1]) res[FIELD_W-1:4] = wd[FIELD_W-1:4];
    return res;
  endfunction
endpackage

// File: rtl/pfw_cfg_regs.sv
module pfw_cfg_regs
  import pfw_pkg::*;
#(
  parameter int CFG_AW = 6,
  parameter int BL_DW  = 9,
  parameter int UB_DW  = 10,
  parameter int UL_DW  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [63:0]       base_eff,
  output logic [63:0]       limit_eff
);
  localparam logic [CFG_AW-1:0] BL_IDX = CFG_AW'(BL_DW);
  localparam logic [CFG_AW-1:0] UB_IDX = CFG_AW'(UB_DW);
  localparam logic [CFG_AW-1:0] UL_IDX = CFG_AW'(UL_DW);
  localparam int NUM_UPPER = 2;
  localparam int BYTES     = HALF_W / 8;

  logic [FIELD_W-1:0] base_q, lim_q;
  logic [NUM_UPPER-1:0][HALF_W-1:0] upper_q;
  logic sel_bl, sel_ub, sel_ul;
  logic [NUM_UPPER-1:0][BYTES-1:0] upper_we;

  assign sel_bl = (cfg_addr == BL_IDX);
  assign sel_ub = (cfg_addr == UB_IDX);
  assign sel_ul = (cfg_addr == UL_IDX);

  for (genvar b = 0; b < BYTES; b++) begin : g_upper_we
    assign upper_we[0][b] = cfg_we & sel_ub & cfg_be[b];
    assign upper_we[1][b] = cfg_we & sel_ul & cfg_be[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      lim_q   <= '0;
      upper_q <= '0;
    end else begin
      if (cfg_we && sel_bl) begin
        base_q <= merge_field(base_q, cfg_wdata[15:4], cfg_be[1:0]);
        lim_q  <= merge_field(lim_q,  cfg_wdata[31:20], cfg_be[3:2]);
      end
      for (int r = 0; r < NUM_UPPER; r++) begin
        for (int b = 0; b < BYTES; b++) begin
          if (upper_we[r][b]) upper_q[r][8*b +: 8] <= cfg_wdata[8*b +: 8];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (sel_bl)      cfg_rdata = {lim_q, CAP64_NIBBLE, base_q, CAP64_NIBBLE};
    else if (sel_ub) cfg_rdata = upper_q[0];
    else if (sel_ul) cfg_rdata = upper_q[1];
  end

  assign base_eff  = {upper_q[0], base_q, {GRAN_BITS{1'b0}}};
  assign limit_eff = {upper_q[1], lim_q,  {GRAN_BITS{1'b1}}};

  // R2: writes to foreign dwords leave every register untouched
  a_r2_foreign_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !sel_bl && !sel_ub && !sel_ul) |=>
      ($stable(base_q) && $stable(lim_q) && $stable(upper_q)));

  // R2: a write with no byte enabled changes nothing
  a_r2_no_lane_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_be == 4'b0000) |=>
      ($stable(base_q) && $stable(lim_q) && $stable(upper_q)));
endmodule

// File: rtl/pfw_range_match.sv
module pfw_range_match
  import pfw_pkg::*;
(
  input  logic [63:0] base_eff,
  input  logic [63:0] limit_eff,
  input  logic [63:0] addr,
  input  logic        dac,
  output logic        hit
);
  logic [63:0] addr_eff;
  logic        above_base, below_limit;

  assign addr_eff    = dac ? addr : {{HALF_W{1'b0}}, addr[HALF_W-1:0]};
  assign above_base  = (addr_eff >= base_eff);
  assign below_limit = (addr_eff <= limit_eff);
  assign hit         = above_base & below_limit;
endmodule

// File: rtl/pfw_claim_stage.sv
module pfw_claim_stage
  import pfw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic hit,
  input  logic from_sec,
  input  logic io_hit,
  input  logic vga_hit,
  input  logic mem_en,
  output logic out_valid,
  input  logic out_ready,
  output claim_t claim
);
  logic   accept;
  claim_t next_claim;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    next_claim.down = mem_en && !from_sec && hit;
    next_claim.up   = mem_en && from_sec && !hit && !io_hit && !vga_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      claim     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      claim     <= next_claim;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(claim)));

  a_r10_result_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  a_r11_claims_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(claim.down && claim.up));

  a_r9_mem_off_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mem_en) |=> (!claim.down && !claim.up));

  a_r7_primary_never_up: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !from_sec) |=> !claim.up);

  a_r8_secondary_never_down: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && from_sec) |=> !claim.down);
endmodule

// File: rtl/pfw_window_decoder.sv
module pfw_window_decoder
  import pfw_pkg::*;
#(
  parameter int CFG_AW = 6,
  parameter int BL_DW  = 9,
  parameter int UB_DW  = 10,
  parameter int UL_DW  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              mem_en,
  input  logic              txn_valid,
  output logic              txn_ready,
  input  logic [63:0]       txn_addr,
  input  logic              txn_dac,
  input  logic              txn_from_sec,
  input  logic              io_win_hit,
  input  logic              vga_hit,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_down,
  output logic              res_up
);
  logic [63:0] base_eff, limit_eff;
  logic        hit;
  claim_t      claim;

  pfw_cfg_regs #(
    .CFG_AW(CFG_AW), .BL_DW(BL_DW), .UB_DW(UB_DW), .UL_DW(UL_DW)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .base_eff(base_eff), .limit_eff(limit_eff)
  );

  pfw_range_match i_match (
    .base_eff(base_eff), .limit_eff(limit_eff),
    .addr(txn_addr), .dac(txn_dac), .hit(hit)
  );

  pfw_claim_stage i_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(txn_valid), .in_ready(txn_ready),
    .hit(hit), .from_sec(txn_from_sec), .io_hit(io_win_hit), .vga_hit(vga_hit),
    .mem_en(mem_en), .out_valid(res_valid), .out_ready(res_ready), .claim(claim)
  );

  assign res_down = claim.down;
  assign res_up   = claim.up;

  // R6: a reversed window never produces a downstream claim
  a_r6_reversed_window_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready && (base_eff > limit_eff)) |=> !res_down);

  // R4: single-cycle access cannot reach a window whose upper base is non-zero
  a_r4_sac_above_4g_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready && !txn_dac && (base_eff[63:32] != '0)) |=> !res_down);
endmodule

// File: tb/test_pfw_window_decoder.sv
module test_pfw_window_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_en = 1'b1;
  logic        txn_valid = 1'b0;
  logic        txn_ready;
  logic [63:0] txn_addr = '0;
  logic        txn_dac = 1'b0;
  logic        txn_from_sec = 1'b0;
  logic        io_win_hit = 1'b0;
  logic        vga_hit = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_down, res_up;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  logic bp_on = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  // shadow of programmed state, kept from the requirements
  logic [11:0] sh_base = '0, sh_lim = '0;
  logic [31:0] sh_ub = '0, sh_ul = '0;

  pfw_window_decoder i_pfw_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_en(mem_en), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_addr(txn_addr), .txn_dac(txn_dac), .txn_from_sec(txn_from_sec),
    .io_win_hit(io_win_hit), .vga_hit(vga_hit), .res_valid(res_valid),
    .res_ready(res_ready), .res_down(res_down), .res_up(res_up)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] model(input logic [63:0] a, input logic dac,
                                       input logic sec, input logic io,
                                       input logic vga, input logic men);
    logic [63:0] ae, b, l;
    logic hit;
    ae  = dac ? a : {32'h0, a[31:0]};
    b   = {sh_ub, sh_base, 20'h00000};
    l   = {sh_ul, sh_lim, 20'hFFFFF};
    hit = (ae >= b) && (ae <= l);
    return {men && !sec && hit, men && sec && !hit && !io && !vga};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    logic [15:0] r;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 6'd9) begin
      r = {sh_base, 4'h1};
      if (be[0]) r[7:0]  = d[7:0];
      if (be[1]) r[15:8] = d[15:8];
      sh_base = r[15:4];
      r = {sh_lim, 4'h1};
      if (be[2]) r[7:0]  = d[23:16];
      if (be[3]) r[15:8] = d[31:24];
      sh_lim = r[15:4];
    end else if (a == 6'd10 || a == 6'd11) begin
      for (int b = 0; b < 4; b++) begin
        if (be[b]) begin
          if (a == 6'd10) sh_ub[8*b +: 8] = d[8*b +: 8];
          else            sh_ul[8*b +: 8] = d[8*b +: 8];
        end
      end
    end
  endtask

  task automatic cfg_read_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic send(input string tag, input logic [63:0] a, input logic dac,
                      input logic sec, input logic io, input logic vga, input logic men);
    @(negedge clk);
    txn_addr = a; txn_dac = dac; txn_from_sec = sec;
    io_win_hit = io; vga_hit = vga; mem_en = men; txn_valid = 1'b1;
    while (!txn_ready) @(negedge clk);
    exp_q.push_back(model(a, dac, sec, io, vga, men));
    tag_q.push_back(tag);
    @(posedge clk);
    #1 txn_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && (exp_q.size() != 0 || res_valid); i++) @(negedge clk);
  endtask

  // scoreboard monitor: a handshake seen here completes at the next edge
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R10: unexpected result down=%0b up=%0b expected none", res_down, res_up);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if ({res_down, res_up} !== e) begin
          mismatched++;
          $display("FAIL %s: got down=%0b up=%0b expected down=%0b up=%0b",
                   t, res_down, res_up, e[1], e[0]);
        end
      end
    end
  end

  // consumer stall generator
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    res_ready = bp_on ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R10 reset state
    @(negedge clk);
    check("R10 idle after reset", {31'h0, res_valid}, 32'h0);
    check("R10 ready after reset", {31'h0, txn_ready}, 32'h1);
    cfg_read_check("R1 base/limit dword", 6'd9, 32'h0001_0001);
    cfg_read_check("R1 upper base", 6'd10, 32'h0);
    cfg_read_check("R1 upper limit", 6'd11, 32'h0);
    send("R1 bottom address", 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R1 top of first MB", 64'h000F_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R1 just above", 64'h0010_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R8 secondary outside", 64'h0010_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    send("R8 secondary inside", 64'h0008_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    drain();

    // R2 / R3 layout and boundaries
    cfg_write(6'd9, 4'hF, 32'h456F_123F);
    cfg_read_check("R2 read-only nibbles", 6'd9, 32'h4561_1231);
    send("R3 base edge", 64'h1230_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R3 below base", 64'h122F_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R3 limit edge", 64'h456F_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R3 above limit", 64'h4570_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R7 primary outside no up", 64'h4570_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    drain();

    // R2 byte lanes, R6 reversed lower fields
    cfg_write(6'd9, 4'b0010, 32'hFFFF_FFFF);
    cfg_read_check("R2 byte enable", 6'd9, 32'h4561_FF31);
    send("R6 reversed primary", 64'hFF30_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R6 reversed secondary", 64'h2000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    drain();

    // R4 / R5 64-bit window
    cfg_write(6'd9, 4'hF, 32'hFFF0_0000);
    cfg_write(6'd10, 4'hF, 32'h1);
    cfg_write(6'd11, 4'hF, 32'h1);
    cfg_read_check("R2 upper base", 6'd10, 32'h1);
    cfg_read_check("R2 upper limit", 6'd11, 32'h1);
    send("R5 dac inside", 64'h1_8000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R5 dac above", 64'h2_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R4 sac low", 64'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R4 sac ignores upper bits", 64'h1_8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R4 sac secondary up", 64'h1_8000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    drain();

    // R6 decided by upper halves, then by lower with equal uppers
    cfg_write(6'd10, 4'b0001, 32'h2);
    send("R6 upper reversed", 64'h1_8000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    cfg_write(6'd10, 4'hF, 32'h1);
    cfg_write(6'd9, 4'hF, 32'h7FF0_8000);
    send("R6 lower reversed", 64'h1_8000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R6 reversed secondary up", 64'h1_8000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    drain();

    // R8 suppression, R9 memory disable
    cfg_write(6'd10, 4'hF, 32'h0);
    cfg_write(6'd11, 4'hF, 32'h0);
    cfg_write(6'd9, 4'hF, 32'h1FF0_1000);
    send("R8 io suppresses up", 64'h3000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    send("R8 vga suppresses up", 64'h000A_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    send("R9 disabled primary", 64'h1800_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send("R9 disabled secondary", 64'h3000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    send("R7 primary inside", 64'h1800_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    drain();

    // R2 foreign dword
    cfg_write(6'd5, 4'hF, 32'hFFFF_FFFF);
    cfg_read_check("R2 foreign reads zero", 6'd5, 32'h0);
    cfg_read_check("R2 foreign write ignored", 6'd9, 32'h1FF1_1001);

    // R10 / R11 under random stalls
    bp_on = 1'b1;
    for (int i = 0; i < 40; i++) begin
      send("R10 stalled stream",
           {31'h0, i[2], 32'(i) * 32'h0480_0000}, i[2], i[0],
           (i % 5) == 0, (i % 7) == 3, (i % 9) != 4);
    end
    drain();
    bp_on = 1'b0;
    drain();
    check("R10 queue empty", exp_q.size(), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule